// File: doc/BRIEF.md
# Per-Bank Request Picker with Row-Hit Bypass

This block serves one rank/bank pair of a memory controller. Each cycle it looks at the bank's queue state, the ranking policy's best write and best read candidates, a separate row-hit read candidate, and the bank's timing state. From these it chooses the request that should be decoded into commands next. The result is a registered valid flag and a request index. Ranking the requests and decoding a request into commands are done by neighbouring logic. That logic supplies one "first command is schedulable" flag for each of the three candidates.

A bank that still has decoded commands in flight gets no new choice. In writeback mode, writes take precedence. When no write is waiting, reads are considered only if read bypass is enabled. A row-hit read may take the place of a best read that misses the open row. This happens only if issuing it now leaves the earliest legal precharge no later than the one the row's activate already fixed: the current cycle plus the read-to-precharge delay must not exceed the activate timestamp plus the minimum row-active time.

Top module: `bank_req_picker`

## Requirements
- R1: When the outstanding command count is nonzero, pick_vld is 0 in the next cycle.
- R2: When both the read queue count and the write queue count are zero, pick_vld is 0 in the next cycle.
- R3: In writeback mode with a write candidate present, the write candidate's index is reported if wr_sched_ok is 1. Otherwise nothing is reported, even when reads are available.
- R4: In writeback mode with no write candidate, reads are considered only when cfg_rd_bypass is 1. When it is 0, nothing is reported.
- R5: With cfg_hit_bypass at 1, the hit candidate replaces the best read under three conditions: the best read is not a row hit (or is absent), hit_vld is 1, and cur_cycle + t_rtp <= act_ts + t_ras. Equality counts as allowed.
- R6: No replacement occurs in any of these cases: cfg_hit_bypass is 0, the best read is a row hit, or cur_cycle + t_rtp > act_ts + t_ras. In each case the best read is kept.
- R7: A read choice is reported only if its own schedulable flag is 1. That is rd_sched_ok for the best read and hit_sched_ok for the hit candidate. Otherwise nothing is reported.
- R8: Both timing sums are taken modulo 2^TS_W, the default being 32 bits, and are compared as unsigned values.
- R9: If the row-hit comparison is needed while act_ts_vld is 0, ts_err is 1 in the next cycle and no replacement is made.
- R10: Outputs are registered. A choice appears in the cycle after its inputs are sampled, and reset clears pick_vld, pick_idx and ts_err to 0.
- R11: Outside writeback mode the write candidate is ignored and the read path decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_cnt | input | CNT_W | Outstanding decoded commands for this bank |
| rdq_cnt | input | CNT_W | Read queue occupancy |
| wrq_cnt | input | CNT_W | Write queue occupancy |
| wb_mode | input | 1 | Writeback mode active |
| best_wr_vld | input | 1 | Policy write candidate exists |
| best_wr_idx | input | IDX_W | Index of the write candidate |
| wr_sched_ok | input | 1 | First command of the write candidate is schedulable |
| best_rd_vld | input | 1 | Policy read candidate exists |
| best_rd_idx | input | IDX_W | Index of the read candidate |
| best_rd_hit | input | 1 | Read candidate hits the open row |
| rd_sched_ok | input | 1 | First command of the read candidate is schedulable |
| hit_vld | input | 1 | Row-hit read candidate exists |
| hit_idx | input | IDX_W | Index of the row-hit candidate |
| hit_sched_ok | input | 1 | First command of the row-hit candidate is schedulable |
| act_ts | input | TS_W | Cycle of the bank's last activate |
| act_ts_vld | input | 1 | act_ts holds a real activate time |
| cur_cycle | input | TS_W | Current cycle |
| t_ras | input | TS_W | Minimum row-active time |
| t_rtp | input | TS_W | Read-to-precharge delay |
| cfg_rd_bypass | input | 1 | Allow reads in writeback mode when no write waits |
| cfg_hit_bypass | input | 1 | Enable row-hit replacement |
| pick_vld | output | 1 | A request is chosen |
| pick_idx | output | IDX_W | Index of the chosen request |
| ts_err | output | 1 | Hit comparison needed with an invalid activate timestamp |

## Verification
The bench uses the default parameters: 4-bit indices, 4-bit counts and 32-bit timestamps. With 32-bit timestamps, cycle values near 2^32 are within reach, so one case has the current-cycle sum wrap past zero while the activate sum does not. In that case the modular comparison and a wide comparison give opposite answers. The small index width makes each candidate's index distinct and easy to tell apart at the output.

// File: rtl/bank_pick_pkg.sv
package bank_pick_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_WR   = 2'd1,
    SRC_RD   = 2'd2,
    SRC_HIT  = 2'd3
  } pick_src_e;
endpackage

// File: rtl/bank_hit_window.sv
module bank_hit_window #(
  parameter int TS_W = 32
) (
  input  logic [TS_W-1:0] act_ts,
  input  logic [TS_W-1:0] cur_cycle,
  input  logic [TS_W-1:0] t_ras,
  input  logic [TS_W-1:0] t_rtp,
  output logic            in_window
);
  logic [TS_W-1:0] pre_limit;
  logic [TS_W-1:0] pre_spec;

  always_comb begin
    pre_limit = act_ts + t_ras;
    pre_spec  = cur_cycle + t_rtp;
    in_window = (pre_spec <= pre_limit);
  end
endmodule

// File: rtl/bank_pick_select.sv
module bank_pick_select
  import bank_pick_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic [CNT_W-1:0] rdq_cnt,
  input  logic [CNT_W-1:0] wrq_cnt,
  input  logic             wb_mode,
  input  logic             best_wr_vld,
  input  logic [IDX_W-1:0] best_wr_idx,
  input  logic             wr_sched_ok,
  input  logic             best_rd_vld,
  input  logic [IDX_W-1:0] best_rd_idx,
  input  logic             best_rd_hit,
  input  logic             rd_sched_ok,
  input  logic             hit_vld,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_sched_ok,
  input  logic             act_ts_vld,
  input  logic             in_window,
  input  logic             cfg_rd_bypass,
  input  logic             cfg_hit_bypass,
  output logic             sel_vld,
  output logic [IDX_W-1:0] sel_idx,
  output logic             sel_ts_bad,
  output pick_src_e        sel_src
);
  logic idle_bank;
  logic rd_path;
  logic hit_try;

  always_comb begin
    idle_bank  = (cmd_cnt == '0) && ((rdq_cnt != '0) || (wrq_cnt != '0));
    rd_path    = idle_bank && (!wb_mode || (!best_wr_vld && cfg_rd_bypass));
    hit_try    = rd_path && cfg_hit_bypass && hit_vld &&
                 !(best_rd_vld && best_rd_hit);
    sel_ts_bad = hit_try && !act_ts_vld;
    sel_vld    = 1'b0;
    sel_idx    = '0;
    sel_src    = SRC_NONE;
    if (idle_bank && wb_mode && best_wr_vld) begin
      sel_src = SRC_WR;
      sel_vld = wr_sched_ok;
      sel_idx = wr_sched_ok ? best_wr_idx : '0;
    end else if (hit_try && act_ts_vld && in_window) begin
      sel_src = SRC_HIT;
      sel_vld = hit_sched_ok;
      sel_idx = hit_sched_ok ? hit_idx : '0;
    end else if (rd_path && best_rd_vld) begin
      sel_src = SRC_RD;
      sel_vld = rd_sched_ok;
      sel_idx = rd_sched_ok ? best_rd_idx : '0;
    end
  end
endmodule

// File: rtl/bank_req_picker.sv
module bank_req_picker
  import bank_pick_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 4,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic [CNT_W-1:0] rdq_cnt,
  input  logic [CNT_W-1:0] wrq_cnt,
  input  logic             wb_mode,
  input  logic             best_wr_vld,
  input  logic [IDX_W-1:0] best_wr_idx,
  input  logic             wr_sched_ok,
  input  logic             best_rd_vld,
  input  logic [IDX_W-1:0] best_rd_idx,
  input  logic             best_rd_hit,
  input  logic             rd_sched_ok,
  input  logic             hit_vld,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             hit_sched_ok,
  input  logic [TS_W-1:0]  act_ts,
  input  logic             act_ts_vld,
  input  logic [TS_W-1:0]  cur_cycle,
  input  logic [TS_W-1:0]  t_ras,
  input  logic [TS_W-1:0]  t_rtp,
  input  logic             cfg_rd_bypass,
  input  logic             cfg_hit_bypass,
  output logic             pick_vld,
  output logic [IDX_W-1:0] pick_idx,
  output logic             ts_err
);
  logic             in_window;
  logic             sel_vld;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_ts_bad;
  pick_src_e        sel_src;

  bank_hit_window #(.TS_W(TS_W)) u_window (
    .act_ts    (act_ts),
    .cur_cycle (cur_cycle),
    .t_ras     (t_ras),
    .t_rtp     (t_rtp),
    .in_window (in_window)
  );

  bank_pick_select #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_select (
    .cmd_cnt        (cmd_cnt),
    .rdq_cnt        (rdq_cnt),
    .wrq_cnt        (wrq_cnt),
    .wb_mode        (wb_mode),
    .best_wr_vld    (best_wr_vld),
    .best_wr_idx    (best_wr_idx),
    .wr_sched_ok    (wr_sched_ok),
    .best_rd_vld    (best_rd_vld),
    .best_rd_idx    (best_rd_idx),
    .best_rd_hit    (best_rd_hit),
    .rd_sched_ok    (rd_sched_ok),
    .hit_vld        (hit_vld),
    .hit_idx        (hit_idx),
    .hit_sched_ok   (hit_sched_ok),
    .act_ts_vld     (act_ts_vld),
    .in_window      (in_window),
    .cfg_rd_bypass  (cfg_rd_bypass),
    .cfg_hit_bypass (cfg_hit_bypass),
    .sel_vld        (sel_vld),
    .sel_idx        (sel_idx),
    .sel_ts_bad     (sel_ts_bad),
    .sel_src        (sel_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pick_vld <= 1'b0;
      pick_idx <= '0;
      ts_err   <= 1'b0;
    end else begin
      pick_vld <= sel_vld;
      pick_idx <= sel_idx;
      ts_err   <= sel_ts_bad;
    end
  end

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_cnt != '0) |=> !pick_vld); // R1
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rdq_cnt == '0 && wrq_cnt == '0) |=> !pick_vld); // R2
  AST_WB_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (cmd_cnt == '0 && wrq_cnt != '0 && wb_mode && best_wr_vld && wr_sched_ok)
    |=> (pick_vld && pick_idx == $past(best_wr_idx))); // R3
  AST_WB_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wb_mode && best_wr_vld && !wr_sched_ok) |=> !pick_vld); // R3
  AST_WB_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (wb_mode && !best_wr_vld && !cfg_rd_bypass) |=> !pick_vld); // R4
  AST_TS_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ts_err |-> !$past(act_ts_vld)); // R9
  AST_ERR_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (ts_err && pick_vld) |-> (pick_idx == $past(best_rd_idx))); // R9
endmodule

// File: tb/bank_req_picker_tb.sv
module bank_req_picker_tb;
  localparam int IDX_W = 4;
  localparam int CNT_W = 4;
  localparam int TS_W  = 32;

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] cmd_cnt, rdq_cnt, wrq_cnt;
  logic             wb_mode, best_wr_vld, wr_sched_ok;
  logic [IDX_W-1:0] best_wr_idx, best_rd_idx, hit_idx;
  logic             best_rd_vld, best_rd_hit, rd_sched_ok;
  logic             hit_vld, hit_sched_ok, act_ts_vld;
  logic [TS_W-1:0]  act_ts, cur_cycle, t_ras, t_rtp;
  logic             cfg_rd_bypass, cfg_hit_bypass;
  logic             pick_vld, ts_err;
  logic [IDX_W-1:0] pick_idx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bank_req_picker #(.IDX_W(IDX_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_cnt(cmd_cnt), .rdq_cnt(rdq_cnt), .wrq_cnt(wrq_cnt),
    .wb_mode(wb_mode), .best_wr_vld(best_wr_vld), .best_wr_idx(best_wr_idx),
    .wr_sched_ok(wr_sched_ok), .best_rd_vld(best_rd_vld), .best_rd_idx(best_rd_idx),
    .best_rd_hit(best_rd_hit), .rd_sched_ok(rd_sched_ok), .hit_vld(hit_vld),
    .hit_idx(hit_idx), .hit_sched_ok(hit_sched_ok), .act_ts(act_ts),
    .act_ts_vld(act_ts_vld), .cur_cycle(cur_cycle), .t_ras(t_ras), .t_rtp(t_rtp),
    .cfg_rd_bypass(cfg_rd_bypass), .cfg_hit_bypass(cfg_hit_bypass),
    .pick_vld(pick_vld), .pick_idx(pick_idx), .ts_err(ts_err)
  );

  task automatic base();
    cmd_cnt = 0; rdq_cnt = 2; wrq_cnt = 2;
    wb_mode = 0; best_wr_vld = 1; best_wr_idx = 4'd9; wr_sched_ok = 1;
    best_rd_vld = 1; best_rd_idx = 4'd3; best_rd_hit = 0; rd_sched_ok = 1;
    hit_vld = 1; hit_idx = 4'd12; hit_sched_ok = 1;
    act_ts = 32'd100; act_ts_vld = 1; cur_cycle = 32'd110;
    t_ras = 32'd30; t_rtp = 32'd5;
    cfg_rd_bypass = 0; cfg_hit_bypass = 0;
  endtask

  task automatic expect_out(string req, logic ev, logic [IDX_W-1:0] ei, logic ee);
    @(posedge clk); #1;
    checks++;
    if (pick_vld !== ev || (ev && pick_idx !== ei) || ts_err !== ee) begin
      errors++;
      $display("FAIL %s: got vld=%0b idx=%0d err=%0b, expected vld=%0b idx=%0d err=%0b",
               req, pick_vld, pick_idx, ts_err, ev, ei, ee);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; base();
    @(posedge clk); #1;
    checks++;
    if (pick_vld !== 0 || pick_idx !== 0 || ts_err !== 0) begin
      errors++;
      $display("FAIL R10 reset: got vld=%0b idx=%0d err=%0b, expected 0 0 0", pick_vld, pick_idx, ts_err);
    end
    @(negedge clk); rst = 0;
  endtask

  task automatic t_latency();
    base(); expect_out("R10 one-cycle read", 1, 4'd3, 0);
  endtask

  task automatic t_busy();
    base(); cmd_cnt = 1; expect_out("R1 busy", 0, 0, 0);
  endtask

  task automatic t_empty();
    base(); rdq_cnt = 0; wrq_cnt = 0; expect_out("R2 empty", 0, 0, 0);
  endtask

  task automatic t_wb_write();
    base(); wb_mode = 1; expect_out("R3 write wins", 1, 4'd9, 0);
    base(); wb_mode = 1; wr_sched_ok = 0; cfg_rd_bypass = 1;
    expect_out("R3 write blocked", 0, 0, 0);
  endtask

  task automatic t_wb_bypass();
    base(); wb_mode = 1; best_wr_vld = 0; expect_out("R4 no bypass", 0, 0, 0);
    base(); wb_mode = 1; best_wr_vld = 0; cfg_rd_bypass = 1;
    expect_out("R4 bypass read", 1, 4'd3, 0);
  endtask

  task automatic t_outside_wb();
    base(); wb_mode = 0; best_wr_vld = 1; rd_sched_ok = 1;
    expect_out("R11 write ignored", 1, 4'd3, 0);
  endtask

  task automatic t_hit();
    base(); cfg_hit_bypass = 1; expect_out("R5 hit replaces", 1, 4'd12, 0);
    base(); cfg_hit_bypass = 1; cur_cycle = 32'd125; expect_out("R5 equality", 1, 4'd12, 0);
    base(); cfg_hit_bypass = 1; best_rd_vld = 0; expect_out("R5 no best read", 1, 4'd12, 0);
    base(); cfg_hit_bypass = 1; cur_cycle = 32'd126; expect_out("R6 window closed", 1, 4'd3, 0);
    base(); cfg_hit_bypass = 1; best_rd_hit = 1; expect_out("R6 best is hit", 1, 4'd3, 0);
    base(); expect_out("R6 bypass off", 1, 4'd3, 0);
  endtask

  task automatic t_sched();
    base(); rd_sched_ok = 0; expect_out("R7 read not sched", 0, 0, 0);
    base(); cfg_hit_bypass = 1; hit_sched_ok = 0; expect_out("R7 hit not sched", 0, 0, 0);
  endtask

  task automatic t_wrap();
    base(); cfg_hit_bypass = 1; cur_cycle = 32'hFFFF_FFF0; t_rtp = 32'h20;
    act_ts = 32'd5; t_ras = 32'h10;
    expect_out("R8 wrap", 1, 4'd12, 0);
  endtask

  task automatic t_bad_ts();
    base(); cfg_hit_bypass = 1; act_ts_vld = 0; expect_out("R9 bad ts", 1, 4'd3, 1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset(); t_latency(); t_busy(); t_empty(); t_wb_write();
        t_wb_bypass(); t_outside_wb(); t_hit(); t_sched(); t_wrap(); t_bad_ts();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule